// File: doc/BRIEF.md
# BCD Seven-Segment Digit Slice with Zero Suppression

This block is one digit of a numeric readout. It takes a four-bit binary-coded-decimal value and keeps it in a holding register whose load is controlled by a level enable. The held value is then decoded into seven active-high segment drives, named a through g. Three overrides act on the decoded value: a lamp test that lights every segment, a blanking control that turns every segment off, and automatic blanking of codes that are not decimal digits.

Several slices can be chained through a ripple-blank input and output. This suppresses zeroes that carry no meaning. For leading-zero suppression, the chain input of the most significant digit is tied high and each digit's ripple-blank output drives the input of the next less significant digit. For trailing-zero suppression, the chain runs the other way. A digit blanks its zero only when its chain input is high. It passes suppression on only when it is itself a suppressed zero.

The held value is registered on the clock edge: while the hold control is low, a new value is loaded on every edge. Everything after the register is combinational.

Top module: `bcd_seg_slice`

## Requirements
- R1: While reset is asserted and afterwards until the first load, the held code is 0. With lamp test and blanking inactive and the chain input low, seg_o shows 7'h7E and rb_out_o is 0.
- R2: While hold_i is low, code_i is loaded into the held code on each rising clock edge. The segments reflect the new code after that edge and not before it.
- R3: While hold_i is high, the held code does not change, and changes on code_i have no effect on seg_o.
- R4: For held codes 0 to 9, seg_o carries the pattern with segment a in bit 6 down to segment g in bit 0: 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=1F, 7=70, 8=7F, 9=73.
- R5: A held code of 10 to 15 gives seg_o = 0.
- R6: lamp_test_ni low forces seg_o to 7'h7F regardless of every other input, and this takes effect in the same cycle.
- R7: blank_ni low while lamp_test_ni is high forces seg_o to 0 in the same cycle.
- R8: With the chain input high, a held code of 0 gives seg_o = 0 instead of the zero pattern.
- R9: rb_out_o is 1 exactly when rb_in_i is 1, the held code is 0, and both lamp_test_ni and blank_ni are high.
- R10: Slices chained for leading-zero suppression blank every zero to the left of the first nonzero digit and show every digit from that one onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the code register |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the held code |
| code_i | input | 4 | BCD code, bit 3 most significant |
| hold_i | input | 1 | 1 keeps the held code, 0 loads code_i on every edge |
| lamp_test_ni | input | 1 | Active-low lamp test, highest priority |
| blank_ni | input | 1 | Active-low blanking |
| rb_in_i | input | 1 | Ripple-blank chain input |
| seg_o | output | 7 | Segment drives, bit 6 = a, bit 0 = g, 1 = lit |
| rb_out_o | output | 1 | Ripple-blank chain output |

## Verification
A new code affects the segments one edge after it is applied with the hold control low. The bench therefore drives inputs on the falling edge and compares on the following falling edge, after exactly one rising edge. In one case it also samples before that edge to confirm that the old pattern is still shown. Lamp test, blanking and the chain input act without any register, so those results are compared in the same cycle in which the stimulus is applied. The chained slices are combinational from one slice to the next, so the whole readout is settled one edge after the digits are loaded.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned SEG_W   = 7;
  localparam int unsigned MAX_DIG = 9;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  localparam seg_t SEG_ALL_ON  = '1;
  localparam seg_t SEG_ALL_OFF = '0;
endpackage

// File: rtl/bcd_code_hold.sv
module bcd_code_hold #(
  parameter int unsigned W = seg_pkg::CODE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (!hold_i) q_o <= d_i;
  end
endmodule

// File: rtl/bcd_seg_decode.sv
module bcd_seg_decode
  import seg_pkg::*;
(
  input  code_t code_i,
  output seg_t  pat_o,
  output logic  legal_o,
  output logic  zero_o
);
  assign legal_o = (code_i <= code_t'(MAX_DIG));
  assign zero_o  = (code_i == '0);

  // bit 6 = a .. bit 0 = g
  always_comb begin
    unique case (code_i)
      4'd0:    pat_o = 7'b1111110;
      4'd1:    pat_o = 7'b0110000;
      4'd2:    pat_o = 7'b1101101;
      4'd3:    pat_o = 7'b1111001;
      4'd4:    pat_o = 7'b0110011;
      4'd5:    pat_o = 7'b1011011;
      4'd6:    pat_o = 7'b0011111;
      4'd7:    pat_o = 7'b1110000;
      4'd8:    pat_o = 7'b1111111;
      4'd9:    pat_o = 7'b1110011;
      default: pat_o = SEG_ALL_OFF;
    endcase
  end
endmodule

// File: rtl/seg_blank_ctrl.sv
module seg_blank_ctrl
  import seg_pkg::*;
(
  input  seg_t pat_i,
  input  logic legal_i,
  input  logic zero_i,
  input  logic lamp_test_ni,
  input  logic blank_ni,
  input  logic rb_in_i,
  output seg_t seg_o,
  output logic rb_out_o
);
  logic forced;
  logic suppress;

  assign forced   = !lamp_test_ni || !blank_ni;
  assign suppress = !legal_i || (zero_i && rb_in_i);

  always_comb begin
    if (!lamp_test_ni)             seg_o = SEG_ALL_ON;
    else if (!blank_ni || suppress) seg_o = SEG_ALL_OFF;
    else                           seg_o = pat_i;
  end

  // a forced display never passes suppression on
  assign rb_out_o = rb_in_i && zero_i && !forced;
endmodule

// File: rtl/bcd_seg_slice.sv
module bcd_seg_slice
  import seg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              hold_i,
  input  logic              lamp_test_ni,
  input  logic              blank_ni,
  input  logic              rb_in_i,
  output logic [SEG_W-1:0]  seg_o,
  output logic              rb_out_o
);
  code_t held_code;
  seg_t  pat;
  logic  legal;
  logic  zero;

  bcd_code_hold #(.W(CODE_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold_i),
    .d_i    (code_i),
    .q_o    (held_code)
  );

  bcd_seg_decode u_dec (
    .code_i  (held_code),
    .pat_o   (pat),
    .legal_o (legal),
    .zero_o  (zero)
  );

  seg_blank_ctrl u_ctl (
    .pat_i        (pat),
    .legal_i      (legal),
    .zero_i       (zero),
    .lamp_test_ni (lamp_test_ni),
    .blank_ni     (blank_ni),
    .rb_in_i      (rb_in_i),
    .seg_o        (seg_o),
    .rb_out_o     (rb_out_o)
  );
endmodule

// File: rtl/bcd_seg_slice_chk.sv
module bcd_seg_slice_chk
  import seg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_i,
  input logic              hold_i,
  input logic              lamp_test_ni,
  input logic              blank_ni,
  input logic              rb_in_i,
  input logic [SEG_W-1:0]  seg_o,
  input logic              rb_out_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_lamp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lamp_test_ni |-> seg_o == 7'h7F);

  p_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_ni && !blank_ni) |-> (seg_o == '0 && !rb_out_o));

  p_rbo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_out_o |-> (rb_in_i && seg_o == '0 && lamp_test_ni && blank_ni));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(hold_i) && $stable(lamp_test_ni) && $stable(blank_ni)
     && $stable(rb_in_i)) |-> ($stable(seg_o) && $stable(rb_out_o)));

  p_illegal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(hold_i) && $past(code_i) > 4'd9 && lamp_test_ni)
    |-> seg_o == '0);

  p_zero_rbi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(hold_i) && $past(code_i) == '0 && rb_in_i
     && lamp_test_ni && blank_ni) |-> (seg_o == '0 && rb_out_o));
endmodule

bind bcd_seg_slice bcd_seg_slice_chk chk_i (.*);

// File: tb/bcd_seg_slice_tb_top.sv
module bcd_seg_slice_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] code_i = '0;
  logic       hold_i = 1'b0;
  logic       lamp_test_ni = 1'b1;
  logic       blank_ni = 1'b1;
  logic       rb_in_i = 1'b0;
  logic [6:0] seg_o;
  logic       rb_out_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  bcd_seg_slice dut_i (.*);

  // four-digit chain, index 3 most significant, leading-zero suppression
  logic [3:0] ch_code [4];
  logic [6:0] ch_seg  [4];
  logic [4:0] ch_rb;
  assign ch_rb[4] = 1'b1;
  for (genvar k = 0; k < 4; k++) begin : chain_g
    bcd_seg_slice dig_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .code_i(ch_code[k]), .hold_i(1'b0),
      .lamp_test_ni(1'b1), .blank_ni(1'b1), .rb_in_i(ch_rb[k+1]),
      .seg_o(ch_seg[k]), .rb_out_o(ch_rb[k])
    );
  end

  // {code, lt_n, bi_n, rbi, seg, rbo}
  localparam int NV = 22;
  localparam logic [14:0] VEC [NV] = '{
    {4'd0, 3'b110, 7'h7E, 1'b0}, {4'd0, 3'b111, 7'h00, 1'b1},
    {4'd1, 3'b110, 7'h30, 1'b0}, {4'd2, 3'b111, 7'h6D, 1'b0},
    {4'd3, 3'b110, 7'h79, 1'b0}, {4'd4, 3'b111, 7'h33, 1'b0},
    {4'd5, 3'b110, 7'h5B, 1'b0}, {4'd6, 3'b111, 7'h1F, 1'b0},
    {4'd7, 3'b110, 7'h70, 1'b0}, {4'd8, 3'b111, 7'h7F, 1'b0},
    {4'd9, 3'b110, 7'h73, 1'b0}, {4'd10, 3'b110, 7'h00, 1'b0},
    {4'd13, 3'b111, 7'h00, 1'b0}, {4'd15, 3'b110, 7'h00, 1'b0},
    {4'd5, 3'b010, 7'h7F, 1'b0}, {4'd0, 3'b011, 7'h7F, 1'b0},
    {4'd12, 3'b001, 7'h7F, 1'b0}, {4'd7, 3'b100, 7'h00, 1'b0},
    {4'd0, 3'b101, 7'h00, 1'b0}, {4'd0, 3'b111, 7'h00, 1'b1},
    {4'd11, 3'b111, 7'h00, 1'b0}, {4'd9, 3'b111, 7'h73, 1'b0}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] pat(input logic [3:0] c, input logic sup);
    logic [6:0] p;
    case (c)
      4'd0: p = 7'h7E; 4'd1: p = 7'h30; 4'd2: p = 7'h6D; 4'd3: p = 7'h79;
      4'd4: p = 7'h33; 4'd5: p = 7'h5B; 4'd6: p = 7'h1F; 4'd7: p = 7'h70;
      4'd8: p = 7'h7F; 4'd9: p = 7'h73; default: p = 7'h00;
    endcase
    return sup ? 7'h00 : p;
  endfunction

  task automatic chain_test(input logic [15:0] num);
    logic lead;
    for (int k = 0; k < 4; k++) ch_code[k] = num[4*k +: 4];
    @(negedge clk_i);
    lead = 1'b1;
    for (int k = 3; k >= 0; k--) begin
      lead = lead && (num[4*k +: 4] == 4'd0);
      check($sformatf("R10 digit %0d of %h", k, num), {1'b0, ch_seg[k]},
            {1'b0, pat(num[4*k +: 4], lead)});
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) ch_code[k] = '0;
    repeat (3) @(negedge clk_i);
    check("R1 reset", {seg_o, rb_out_o}, {7'h7E, 1'b0});
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", {seg_o, rb_out_o}, {7'h7E, 1'b0});

    // table: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      code_i       = VEC[i][14:11];
      lamp_test_ni = VEC[i][10];
      blank_ni     = VEC[i][9];
      rb_in_i      = VEC[i][8];
      @(negedge clk_i);
      check($sformatf("R4-table vec %0d", i), {seg_o, rb_out_o}, VEC[i][7:0]);
    end
    lamp_test_ni = 1'b1; blank_ni = 1'b1; rb_in_i = 1'b0;

    // R2 timing: old pattern until the edge
    code_i = 4'd2;
    @(negedge clk_i);
    code_i = 4'd4;
    #3 check("R2 before edge", {1'b0, seg_o}, {1'b0, 7'h6D});
    @(negedge clk_i);
    check("R2 after edge", {1'b0, seg_o}, {1'b0, 7'h33});

    // R3 hold
    code_i = 4'd6;
    @(negedge clk_i);
    hold_i = 1'b1;
    code_i = 4'd2;
    repeat (2) @(negedge clk_i);
    check("R3 held 6", {1'b0, seg_o}, {1'b0, 7'h1F});
    code_i = 4'd0; rb_in_i = 1'b1;
    @(negedge clk_i);
    check("R3 held not zero", {seg_o, rb_out_o}, {7'h1F, 1'b0});
    hold_i = 1'b0;
    @(negedge clk_i);
    check("R2 release loads 0", {seg_o, rb_out_o}, {7'h00, 1'b1});
    // R6 same-cycle override
    lamp_test_ni = 1'b0;
    #2 check("R6 same cycle", {seg_o, rb_out_o}, {7'h7F, 1'b0});
    lamp_test_ni = 1'b1; blank_ni = 1'b0;
    #2 check("R7 same cycle, R9 rbo low", {seg_o, rb_out_o}, {7'h00, 1'b0});
    blank_ni = 1'b1; rb_in_i = 1'b0;
    #2 check("R8 rbi low shows 0", {seg_o, rb_out_o}, {7'h7E, 1'b0});

    chain_test(16'h0050);
    chain_test(16'h0000);
    chain_test(16'h0103);
    chain_test(16'h9000);
    chain_test(16'h0007);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule